// File: doc/BRIEF.md
# Auto-Reload Decrementer Timer

This block is a down-counter that runs at the time-base rate. A one-cycle tick enable pulse from an external time base makes it count down by one. When it expires, it sets an interrupt status flag. A level interrupt is driven high while that flag and its enable bit are both set. Software reaches the block through a simple write strobe with a two-bit register select. The select picks one of four targets: the counter, a reload value, the control bits or the status flag.

A parameter fixes the expiry rule at build time. In zero-trigger mode, the count reaching zero is the event, and the counter then stays at zero. In sign-flip mode, the event is the most significant bit going from 0 to 1, which happens as the count wraps from zero to all ones. In this mode a software load that turns the sign bit on also raises the event at once. With auto-reload enabled, the counter takes the reload value at expiry instead.

Top module: `reload_decrementer`

## Requirements
- R1: After reset the count, the reload value, the control bits and the status flag are all zero, and the interrupt output is low.
- R2: A write with select 0 loads the count from the write data on the next clock edge. If a tick arrives in the same cycle, the load wins: that tick neither decrements nor raises an event.
- R3: Each cycle with the tick enable high (and no count write) lowers a count above one by exactly one. With the tick enable low, the count does not change.
- R4: Zero-trigger mode (ZERO_TRIG=1): a tick at count 1 moves the count to 0 and sets the status flag. Ticks at count 0 leave it at 0 and raise no event.
- R5: Sign-flip mode (ZERO_TRIG=0): a tick at count 0 wraps the count to all ones and sets the status flag.
- R6: Sign-flip mode only: a count write whose data has bit 31 set, while the current count has bit 31 clear, sets the status flag on that edge. Such a write raises no event when bit 31 of the current count is already set, and never raises one in zero-trigger mode.
- R7: A write with select 1 stores the reload value. When control bit 22 (auto-reload) is set at expiry, the count takes the reload value instead of 0 (zero-trigger) or all ones (sign-flip).
- R8: A write with select 2 stores control bits 26 (interrupt enable) and 22 (auto-reload). All other data bits of that write have no effect.
- R9: A write with select 3 clears the status flag when data bit 27 is 1. It leaves the flag unchanged when bit 27 is 0. An expiry event in the same cycle as a clear leaves the flag set.
- R10: The interrupt output equals the status flag ANDed with the interrupt enable. It follows any control or status write from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Time-base tick, one cycle per count step |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 count, 1 reload, 2 control, 3 status |
| wrData | input | WIDTH (32) | Write data |
| countOut | output | WIDTH (32) | Current count |
| intStatus | output | 1 | Decrementer interrupt status flag |
| decIrq | output | 1 | Level interrupt, status AND enable |

## Verification
Every result is due one clock edge after its cause, because each output comes straight from a register or from an AND of two registers: count loads, decrements, reloads, status set and clear, and the interrupt after a control write. The bench drives each stimulus on a falling edge and lets exactly one rising edge pass. It then advances its own model and compares all outputs of both mode variants one nanosecond after that edge, before the next stimulus. Same-cycle collisions (load against tick, clear against expiry) are checked at that single edge, so the priority is visible without a second cycle hiding it.

// File: rtl/dectmr_pkg.sv
package dectmr_pkg;

  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_STAT   = 2'd3
  } regSel_e;

  // bit positions decoded by software
  localparam int STAT_BIT   = 27;
  localparam int IRQEN_BIT  = 26;
  localparam int RELOAD_BIT = 22;

  typedef struct packed {
    logic swLoad;     // load count from write data
    logic stepDown;   // count minus one
    logic autoLoad;   // count from reload register
    logic reloadWr;   // store reload register
  } dpStrobe_t;

  typedef struct packed {
    logic isZero;
    logic isOne;
  } cntFlags_t;

endpackage

// File: rtl/dectmr_datapath.sv
module dectmr_datapath
  import dectmr_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] count,
  output cntFlags_t        flags
);

  logic [WIDTH-1:0] reloadVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadVal <= '0;
    end else if (strobe.reloadWr) begin
      reloadVal <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.swLoad) begin
      count <= wrData;
    end else if (strobe.autoLoad) begin
      count <= reloadVal;
    end else if (strobe.stepDown) begin
      count <= count - WIDTH'(1);
    end
  end

  always_comb begin
    flags.isZero = (count == '0);
    flags.isOne  = (count == WIDTH'(1));
  end

  AST_SW_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.swLoad |=> count == $past(wrData)); // R2

endmodule

// File: rtl/dectmr_ctrl.sv
module dectmr_ctrl
  import dectmr_pkg::*;
#(
  parameter bit ZERO_TRIG = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  logic      wrEn,
  input  regSel_e   wrSel,
  input  logic      wrStatBit,
  input  logic      wrIrqEnBit,
  input  logic      wrReloadBit,
  input  logic      signRise,
  input  cntFlags_t flags,
  output dpStrobe_t strobe,
  output logic      statFlag,
  output logic      irqOut
);

  logic irqEn;
  logic autoRel;
  logic swCnt;
  logic tickGo;
  logic expireHit;
  logic tickEvt;
  logic swEvt;
  logic stepDown;

  assign swCnt  = wrEn && (wrSel == SEL_COUNT);
  assign tickGo = tickEn && !swCnt;

  // expiry condition depends on the trigger rule
  assign expireHit = ZERO_TRIG ? flags.isOne : flags.isZero;
  assign tickEvt   = tickGo && expireHit;
  assign swEvt     = !ZERO_TRIG && swCnt && signRise;

  generate
    if (ZERO_TRIG) begin : gZeroHold
      assign stepDown = tickGo && !flags.isZero && !(tickEvt && autoRel);
    end else begin : gWrap
      assign stepDown = tickGo && !(tickEvt && autoRel);
    end
  endgenerate

  always_comb begin
    strobe.swLoad   = swCnt;
    strobe.stepDown = stepDown;
    strobe.autoLoad = tickEvt && autoRel;
    strobe.reloadWr = wrEn && (wrSel == SEL_RELOAD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEn   <= 1'b0;
      autoRel <= 1'b0;
    end else if (wrEn && (wrSel == SEL_CTRL)) begin
      irqEn   <= wrIrqEnBit;
      autoRel <= wrReloadBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statFlag <= 1'b0;
    end else if (tickEvt || swEvt) begin
      statFlag <= 1'b1;
    end else if (wrEn && (wrSel == SEL_STAT) && wrStatBit) begin
      statFlag <= 1'b0;
    end
  end

  assign irqOut = statFlag && irqEn;

  AST_ONE_COUNT_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.swLoad, strobe.stepDown, strobe.autoLoad})); // R2

  AST_EVENT_NOT_LOST: assert property (@(posedge clk) disable iff (!rstN)
    (tickEvt || swEvt) |=> statFlag); // R9

endmodule

// File: rtl/reload_decrementer.sv
module reload_decrementer
  import dectmr_pkg::*;
#(
  parameter int WIDTH     = 32,
  parameter bit ZERO_TRIG = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] countOut,
  output logic             intStatus,
  output logic             decIrq
);

  localparam int MSB = WIDTH - 1;

  dpStrobe_t strobe;
  cntFlags_t flags;
  regSel_e   wrSel;
  logic      signRise;
  logic      swCntWr;

  assign wrSel    = regSel_e'(wrAddr);
  assign signRise = wrData[MSB] && !countOut[MSB];
  assign swCntWr  = wrEn && (wrSel == SEL_COUNT);

  dectmr_ctrl #(
    .ZERO_TRIG(ZERO_TRIG)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .wrStatBit  (wrData[STAT_BIT]),
    .wrIrqEnBit (wrData[IRQEN_BIT]),
    .wrReloadBit(wrData[RELOAD_BIT]),
    .signRise   (signRise),
    .flags      (flags),
    .strobe     (strobe),
    .statFlag   (intStatus),
    .irqOut     (decIrq)
  );

  dectmr_datapath #(
    .WIDTH(WIDTH)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrData(wrData),
    .count (countOut),
    .flags (flags)
  );

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !swCntWr && countOut > WIDTH'(1))
      |=> countOut == $past(countOut) - WIDTH'(1)); // R3

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !swCntWr) |=> $stable(countOut)); // R3

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_STAT && wrData[STAT_BIT] && !tickEn)
      |=> !intStatus); // R9

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    decIrq |-> intStatus); // R10

  generate
    if (ZERO_TRIG) begin : gZeroChk
      AST_ZERO_STICKS: assert property (@(posedge clk) disable iff (!rstN)
        (countOut == '0 && !swCntWr) |=> countOut == '0); // R4
    end else begin : gWrapChk
      AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
        (tickEn && !swCntWr && countOut == '0) |=> intStatus); // R5
    end
  endgenerate

endmodule

// File: tb/reload_decrementer_tb.sv
`timescale 1ns/1ps
module reload_decrementer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [31:0] wrData = '0;

  logic [31:0] cntZ, cntS;
  logic        statZ, statS, irqZ, irqS;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // model state, index 0 zero-trigger, 1 sign-flip
  logic [31:0] mCount [2];
  logic [31:0] mReload [2];
  logic        mStat [2];
  logic        mIe [2];
  logic        mAre [2];

  always #2 clk = ~clk;

  reload_decrementer #(.WIDTH(32), .ZERO_TRIG(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .countOut(cntZ), .intStatus(statZ), .decIrq(irqZ));

  reload_decrementer #(.WIDTH(32), .ZERO_TRIG(1'b0)) u_dutSign (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .countOut(cntS), .intStatus(statS), .decIrq(irqS));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void modelReset();
    for (int m = 0; m < 2; m++) begin
      mCount[m] = '0; mReload[m] = '0; mStat[m] = 1'b0;
      mIe[m] = 1'b0; mAre[m] = 1'b0;
    end
  endfunction

  // next state from the requirements, using inputs of the edge just taken
  function automatic void modelStep();
    for (int m = 0; m < 2; m++) begin
      logic [31:0] nc;
      logic evt;
      logic swCnt;
      nc = mCount[m];
      evt = 1'b0;
      swCnt = wrEn && wrAddr == 2'd0;
      if (swCnt) begin                                   // R2
        if (m == 1 && wrData[31] && !mCount[m][31]) evt = 1'b1;  // R6
        nc = wrData;
      end else if (tickEn) begin
        if (m == 0) begin
          if (mCount[m] == 32'd1) begin                  // R4
            evt = 1'b1;
            nc = mAre[m] ? mReload[m] : 32'd0;           // R7
          end else if (mCount[m] != 32'd0) begin
            nc = mCount[m] - 32'd1;                      // R3
          end
        end else begin
          if (mCount[m] == 32'd0) begin                  // R5
            evt = 1'b1;
            nc = mAre[m] ? mReload[m] : 32'hFFFF_FFFF;
          end else begin
            nc = mCount[m] - 32'd1;
          end
        end
      end
      if (evt) mStat[m] = 1'b1;
      else if (wrEn && wrAddr == 2'd3 && wrData[27]) mStat[m] = 1'b0;  // R9
      if (wrEn && wrAddr == 2'd1) mReload[m] = wrData;
      if (wrEn && wrAddr == 2'd2) begin                  // R8
        mIe[m] = wrData[26];
        mAre[m] = wrData[22];
      end
      mCount[m] = nc;
    end
  endfunction

  task automatic compareAll(input string tag);
    chk(cntZ == mCount[0], {tag, " zero-mode count"}, cntZ, mCount[0]);
    chk(statZ == mStat[0], {tag, " zero-mode status"}, 32'(statZ), 32'(mStat[0]));
    chk(irqZ == (mStat[0] && mIe[0]), {tag, " R10 zero-mode irq"}, 32'(irqZ),
        32'(mStat[0] && mIe[0]));
    chk(cntS == mCount[1], {tag, " sign-mode count"}, cntS, mCount[1]);
    chk(statS == mStat[1], {tag, " sign-mode status"}, 32'(statS), 32'(mStat[1]));
    chk(irqS == (mStat[1] && mIe[1]), {tag, " R10 sign-mode irq"}, 32'(irqS),
        32'(mStat[1] && mIe[1]));
  endtask

  task automatic step(input logic t, input logic w, input logic [1:0] a,
                      input logic [31:0] d, input string tag);
    @(negedge clk);
    tickEn = t; wrEn = w; wrAddr = a; wrData = d;
    @(posedge clk);
    modelStep();
    #1;
    compareAll(tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #0.5;
    // R1: reset state
    chk(cntZ == 0 && cntS == 0, "R1 count after reset", cntS | cntZ, 32'd0);
    chk(!statZ && !statS && !irqZ && !irqS, "R1 status/irq after reset",
        32'({statZ, statS, irqZ, irqS}), 32'd0);

    step(1, 0, 2'd0, 0, "R4 R5 tick at zero");
    chk(cntZ == 0 && !statZ, "R4 zero sticks", cntZ, 0);
    chk(cntS == 32'hFFFF_FFFF && statS, "R5 wrap", cntS, 32'hFFFF_FFFF);
    step(0, 1, 2'd3, 32'hF7FF_FFFF, "R9 bit27 zero keeps");
    chk(statS == 1'b1, "R9 status kept", 32'(statS), 1);
    step(0, 1, 2'd3, 32'h0800_0000, "R9 clear");
    chk(statS == 1'b0, "R9 status cleared", 32'(statS), 0);
    step(0, 1, 2'd0, 32'd3, "R2 load");
    chk(cntZ == 3, "R2 load value", cntZ, 3);
    for (int i = 0; i < 3; i++) step(1, 0, 2'd0, 0, "R3 R4 countdown");
    chk(cntZ == 0 && statZ, "R4 expiry at zero", cntZ, 0);
    step(1, 0, 2'd0, 0, "R5 sign wrap");
    step(1, 0, 2'd0, 0, "R4 hold");
    chk(cntS == 32'hFFFF_FFFE, "R3 step after wrap", cntS, 32'hFFFF_FFFE);
    step(0, 1, 2'd2, 32'h0400_0000, "R10 enable irq");
    chk(irqZ == 1'b1, "R10 irq raised", 32'(irqZ), 1);
    step(0, 1, 2'd0, 32'd1, "R2 load one");
    step(1, 1, 2'd3, 32'h0800_0000, "R9 clear vs event");
    chk(statZ == 1'b1, "R9 event beats clear", 32'(statZ), 1);
    step(0, 1, 2'd2, 32'hFBBF_FFFF, "R8 other bits ignored");
    chk(irqZ == 1'b0, "R8 enable off", 32'(irqZ), 0);
    step(0, 1, 2'd1, 32'd4, "R7 reload value");
    step(0, 1, 2'd2, 32'h0440_0000, "R7 auto-reload on");
    step(0, 1, 2'd0, 32'd2, "R2 load two");
    step(1, 0, 2'd0, 0, "R3");
    step(1, 0, 2'd0, 0, "R7 zero-mode reload");
    chk(cntZ == 4, "R7 reloaded", cntZ, 4);
    step(1, 0, 2'd0, 0, "R7 sign-mode reload");
    chk(cntS == 4, "R7 sign reloaded", cntS, 4);
    step(1, 1, 2'd0, 32'd9, "R2 load beats tick");
    chk(cntZ == 9 && cntS == 9, "R2 load wins", cntS, 9);
    step(0, 1, 2'd3, 32'h0800_0000, "R9 clear");
    step(0, 1, 2'd0, 32'h8000_0000, "R6 sign rise");
    chk(statS == 1'b1 && statZ == 1'b0, "R6 event only sign mode",
        32'({statS, statZ}), 32'b10);
    step(0, 1, 2'd3, 32'h0800_0000, "R9 clear");
    step(0, 1, 2'd0, 32'h9000_0000, "R6 no rise");
    chk(statS == 1'b0, "R6 no event when msb already set", 32'(statS), 0);
    for (int i = 0; i < 3; i++) step(0, 0, 2'd0, 0, "R3 idle");
    chk(cntS == 32'h9000_0000, "R3 idle hold", cntS, 32'h9000_0000);

    for (int i = 0; i < 4000; i++) begin
      logic [1:0] a;
      logic [31:0] d;
      a = 2'($urandom % 4);
      d = ($urandom % 6 == 0) ? $urandom : ($urandom % 8);
      step(1'($urandom % 2), 1'($urandom % 5 == 0), a, d, "R3 random");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule